// File: doc/BRIEF.md
# Shared Address/Data Bus Master Front End

This block sits between a master that drives one shared byte-wide bus and a shared memory that lies outside it. The master tells address from data only by the levels on three active-low control lines: a frame line, an initiator-ready line and a target-ready line. The block decodes those levels on every rising clock edge. It keeps the most recent address in a latch and turns completed phases into single-entry write or read commands for the memory. Read data that the memory returns is registered onto a dedicated master read-data output.

An external arbiter supplies a busy line. The block issues a command only while that line is low. A write whose data phase arrives while busy is high is thrown away, and the block raises a one-cycle error pulse. The command to memory leaves through a valid/ready interface. A command stays on the pins unchanged until the memory accepts it with ready. While the slot is full and not draining, no new command can enter it. A write that arrives then is dropped and flagged. The read-response input has no back-pressure: the memory presents a byte for one cycle with a valid strobe, and the block always takes it.

Top module: `muxbus_master_port`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cmd_valid`, `rd_valid` and `err_drop` are low.
- R2: A rising edge that samples `frame_n`=0, `irdy_n`=1, `trdy_n`=1 (address phase) stores `bus_ad` in the address latch, whether or not busy is high.
- R3: The first edge of a data phase (`frame_n`=1, `irdy_n`=0, `trdy_n`=0) with `wr_n`=0, `mst_busy`=0 and a free slot raises `cmd_valid` after that edge. It also sets `cmd_we`=1, `cmd_addr` to the latched address and `cmd_wdata` to the bus byte.
- R4: A data phase held for several cycles produces exactly one write command.
- R5: An edge that samples a pattern other than address or data, directly after an address-phase edge, with `wr_n`=1, `mst_busy`=0 and a free slot, issues a read command. That command has `cmd_we`=0 and `cmd_addr` set to the latched address.
- R6: A data phase whose first edge sees `mst_busy`=1 issues no command and sets `err_drop` high for exactly the one cycle after that edge.
- R7: A read that would start while `mst_busy`=1 issues no command and raises no error.
- R8: Every frame/irdy/trdy pattern other than the address and data patterns is idle. It leaves the address latch unchanged and issues no write.
- R9: While `cmd_valid`=1 and `cmd_ready`=0, the command fields hold stable. A write data phase that starts while the slot is full and not draining is dropped and pulses `err_drop`.
- R10: `rsp_valid`=1 at an edge makes `rd_valid` high for the next cycle with `rd_data` equal to `rsp_data`. `rd_data` keeps that byte afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_ad | input | 8 | Shared address/data bus |
| frame_n | input | 1 | Frame line, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| wr_n | input | 1 | Write strobe, active low; high requests a read |
| mst_busy | input | 1 | Arbiter busy line for the master; low grants access |
| cmd_valid | output | 1 | Memory command present |
| cmd_ready | input | 1 | Memory accepts the command at this edge |
| cmd_we | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | 8 | Command address |
| cmd_wdata | output | 8 | Write data |
| rsp_valid | input | 1 | Memory read byte present |
| rsp_data | input | 8 | Memory read byte |
| rd_valid | output | 1 | Master read data valid, one cycle |
| rd_data | output | 8 | Master read data |
| err_drop | output | 1 | One-cycle pulse for a dropped write data phase |

## Verification
A phase is decoded at the edge that samples it. The matching command or error pulse is therefore visible right after that same edge. A read byte reaches `rd_valid`/`rd_data` one edge after the memory presents it. In this bench that is one edge after the read command shows, since the memory model answers in the half cycle in between. The bench drives every input one nanosecond after a rising edge and checks the outputs one nanosecond after the next rising edge. Each check therefore looks at exactly the edge that consumed the stimulus. Held-phase and back-pressure cases are checked cycle by cycle, so both a missing command and an extra command are caught.

// File: rtl/mab_pkg.sv
package mab_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  // Level pattern of the three active-low handshake lines -> phase.
  function automatic phase_e classify(input logic fr_n, input logic ir_n, input logic tr_n);
    if (!fr_n && ir_n && tr_n)
      return PH_ADDR;
    else if (fr_n && !ir_n && !tr_n)
      return PH_DATA;
    else
      return PH_IDLE;
  endfunction

endpackage

// File: rtl/mab_phase_dec.sv
module mab_phase_dec
  import mab_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_ad,
  input  logic         frame_n,
  input  logic         irdy_n,
  input  logic         trdy_n,
  input  logic         wr_n,
  output logic [W-1:0] addr_q,
  output logic         data_start,
  output logic         read_start
);

  phase_e cur_ph;
  phase_e prev_ph;

  always_comb cur_ph = classify(frame_n, irdy_n, trdy_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ph <= PH_IDLE;
      addr_q  <= '0;
    end else begin
      prev_ph <= cur_ph;
      if (cur_ph == PH_ADDR)
        addr_q <= bus_ad;
    end
  end

  // First edge of a data phase only; a held pattern does not retrigger.
  always_comb data_start = (cur_ph == PH_DATA) && (prev_ph != PH_DATA);

  // Address phase ended into an idle pattern with the strobe high.
  always_comb read_start = (prev_ph == PH_ADDR) && (cur_ph == PH_IDLE) && wr_n;

endmodule

// File: rtl/mab_cmd_slot.sv
module mab_cmd_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy,
  input  logic         wr_n,
  input  logic         data_start,
  input  logic         read_start,
  input  logic [W-1:0] addr_q,
  input  logic [W-1:0] bus_ad,
  input  logic         cmd_ready,
  output logic         cmd_valid,
  output logic         cmd_we,
  output logic [W-1:0] cmd_addr,
  output logic [W-1:0] cmd_wdata,
  output logic         err_drop
);

  logic slot_free;
  logic load_wr;
  logic load_rd;
  logic drop_now;

  always_comb begin
    slot_free = !cmd_valid || cmd_ready;
    load_wr   = data_start && !wr_n && !busy && slot_free;
    load_rd   = read_start && !busy && slot_free;
    drop_now  = data_start && (busy || (!wr_n && !slot_free));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_we    <= 1'b0;
      cmd_addr  <= '0;
      cmd_wdata <= '0;
      err_drop  <= 1'b0;
    end else begin
      err_drop <= drop_now;
      if (load_wr) begin
        cmd_valid <= 1'b1;
        cmd_we    <= 1'b1;
        cmd_addr  <= addr_q;
        cmd_wdata <= bus_ad;
      end else if (load_rd) begin
        cmd_valid <= 1'b1;
        cmd_we    <= 1'b0;
        cmd_addr  <= addr_q;
      end else if (cmd_ready) begin
        cmd_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mab_rd_return.sv
module mab_rd_return #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rsp_valid,
  input  logic [W-1:0] rsp_data,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rsp_valid;
      if (rsp_valid)
        rd_data <= rsp_data;
    end
  end

endmodule

// File: rtl/muxbus_master_port.sv
module muxbus_master_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_ad,
  input  logic         frame_n,
  input  logic         irdy_n,
  input  logic         trdy_n,
  input  logic         wr_n,
  input  logic         mst_busy,
  output logic         cmd_valid,
  input  logic         cmd_ready,
  output logic         cmd_we,
  output logic [W-1:0] cmd_addr,
  output logic [W-1:0] cmd_wdata,
  input  logic         rsp_valid,
  input  logic [W-1:0] rsp_data,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         err_drop
);

  logic [W-1:0] lat_addr;
  logic         dat_first;
  logic         rd_first;

  mab_phase_dec #(.W(W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ad     (bus_ad),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .trdy_n     (trdy_n),
    .wr_n       (wr_n),
    .addr_q     (lat_addr),
    .data_start (dat_first),
    .read_start (rd_first)
  );

  mab_cmd_slot #(.W(W)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (mst_busy),
    .wr_n       (wr_n),
    .data_start (dat_first),
    .read_start (rd_first),
    .addr_q     (lat_addr),
    .bus_ad     (bus_ad),
    .cmd_ready  (cmd_ready),
    .cmd_valid  (cmd_valid),
    .cmd_we     (cmd_we),
    .cmd_addr   (cmd_addr),
    .cmd_wdata  (cmd_wdata),
    .err_drop   (err_drop)
  );

  mab_rd_return #(.W(W)) u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/muxbus_master_port_chk.sv
module muxbus_master_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] bus_ad,
  input logic         frame_n,
  input logic         irdy_n,
  input logic         trdy_n,
  input logic         wr_n,
  input logic         mst_busy,
  input logic         cmd_valid,
  input logic         cmd_ready,
  input logic         cmd_we,
  input logic [W-1:0] cmd_addr,
  input logic [W-1:0] cmd_wdata,
  input logic         rsp_valid,
  input logic [W-1:0] rsp_data,
  input logic         rd_valid,
  input logic [W-1:0] rd_data,
  input logic         err_drop,
  input logic [W-1:0] lat_addr
);

  // R2
  addr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n && irdy_n && trdy_n) |=> (lat_addr == $past(bus_ad)));

  // R3
  wr_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_valid) && cmd_we) |-> $past(frame_n && !irdy_n && !trdy_n && !wr_n && !mst_busy));

  // R6
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_drop |=> !err_drop);

  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_busy && !cmd_valid) |=> !cmd_valid);

  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_we) && $stable(cmd_addr) && $stable(cmd_wdata)));

  // R10
  rd_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (rd_valid && rd_data == $past(rsp_data)));

endmodule

bind muxbus_master_port muxbus_master_port_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_ad    (bus_ad),
  .frame_n   (frame_n),
  .irdy_n    (irdy_n),
  .trdy_n    (trdy_n),
  .wr_n      (wr_n),
  .mst_busy  (mst_busy),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_we    (cmd_we),
  .cmd_addr  (cmd_addr),
  .cmd_wdata (cmd_wdata),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .err_drop  (err_drop),
  .lat_addr  (lat_addr)
);

// File: tb/tb_muxbus_master_port.sv
`timescale 1ns/1ps
module tb_muxbus_master_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_ad = '0;
  logic       frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, wr_n = 1'b1;
  logic       mst_busy = 1'b0;
  logic       cmd_ready = 1'b1;
  logic       rsp_valid = 1'b0;
  logic [7:0] rsp_data = '0;
  logic       cmd_valid, cmd_we, rd_valid, err_drop;
  logic [7:0] cmd_addr, cmd_wdata, rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] mem [256];

  always #2.5 clk = ~clk;

  muxbus_master_port dut (
    .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .frame_n(frame_n),
    .irdy_n(irdy_n), .trdy_n(trdy_n), .wr_n(wr_n), .mst_busy(mst_busy),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_we(cmd_we),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .err_drop(err_drop)
  );

  // Memory model: acts mid-cycle on a command accepted at the next edge.
  always @(negedge clk) begin
    rsp_valid <= 1'b0;
    if (rst_n && cmd_valid && cmd_ready) begin
      if (cmd_we) mem[cmd_addr] <= cmd_wdata;
      else begin
        rsp_valid <= 1'b1;
        rsp_data  <= mem[cmd_addr];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle of bus levels, then step to just after the sampling edge.
  task automatic step(input logic f, input logic i, input logic t,
                      input logic w, input logic [7:0] ad);
    frame_n = f; irdy_n = i; trdy_n = t; wr_n = w; bus_ad = ad;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk(cmd_valid == 0, "R1", "cmd_valid", cmd_valid, 0);
    chk(rd_valid == 0, "R1", "rd_valid", rd_valid, 0);
    chk(err_drop == 0, "R1", "err_drop", err_drop, 0);
  endtask

  task automatic t_write();
    step(0, 1, 1, 1, 8'h3C);
    step(1, 0, 0, 0, 8'hA5);
    chk(cmd_valid == 1, "R3", "write cmd_valid", cmd_valid, 1);
    chk(cmd_we == 1, "R3", "write cmd_we", cmd_we, 1);
    chk(cmd_addr == 8'h3C, "R2", "write cmd_addr", cmd_addr, 8'h3C);
    chk(cmd_wdata == 8'hA5, "R3", "write cmd_wdata", cmd_wdata, 8'hA5);
    step(1, 1, 1, 0, 8'h00);
    chk(cmd_valid == 0, "R3", "cmd drained", cmd_valid, 0);
  endtask

  task automatic t_hold();
    int n = 0;
    step(0, 1, 1, 0, 8'h10);
    for (int k = 0; k < 3; k++) begin
      step(1, 0, 0, 0, 8'h77);
      if (cmd_valid && cmd_we) n++;
    end
    chk(n == 1, "R4", "writes per held data phase", n, 1);
    step(1, 1, 1, 0, 8'h00);
  endtask

  task automatic t_read();
    step(0, 1, 1, 1, 8'h3C);
    step(1, 1, 1, 1, 8'h00);
    chk(cmd_valid == 1 && cmd_we == 0, "R5", "read cmd valid/we", {cmd_valid, cmd_we}, 2'b10);
    chk(cmd_addr == 8'h3C, "R5", "read cmd_addr", cmd_addr, 8'h3C);
    step(1, 1, 1, 0, 8'h00);
    chk(rd_valid == 1, "R10", "rd_valid", rd_valid, 1);
    chk(rd_data == 8'hA5, "R10", "rd_data", rd_data, 8'hA5);
    step(1, 1, 1, 0, 8'h00);
    chk(rd_valid == 0, "R10", "rd_valid one cycle", rd_valid, 0);
    chk(rd_data == 8'hA5, "R10", "rd_data held", rd_data, 8'hA5);
  endtask

  task automatic t_busy_write();
    mst_busy = 1'b1;
    step(0, 1, 1, 1, 8'h20);
    step(1, 0, 0, 0, 8'h55);
    chk(cmd_valid == 0, "R6", "no cmd while busy", cmd_valid, 0);
    chk(err_drop == 1, "R6", "err pulse", err_drop, 1);
    step(1, 0, 0, 0, 8'h55);
    chk(err_drop == 0, "R6", "err one cycle", err_drop, 0);
    mst_busy = 1'b0;
    step(0, 1, 1, 1, 8'h20);
    step(1, 1, 1, 1, 8'h00);
    step(1, 1, 1, 0, 8'h00);
    chk(rd_valid == 1 && rd_data == 8'h00, "R6", "dropped byte not stored", rd_data, 0);
  endtask

  task automatic t_busy_read();
    mst_busy = 1'b1;
    step(0, 1, 1, 1, 8'h3C);
    step(1, 1, 1, 1, 8'h00);
    chk(cmd_valid == 0, "R7", "no read while busy", cmd_valid, 0);
    chk(err_drop == 0, "R7", "no err on busy read", err_drop, 0);
    mst_busy = 1'b0;
    step(1, 1, 1, 0, 8'h00);
  endtask

  task automatic t_idle();
    logic [2:0] pats [5] = '{3'b001, 3'b010, 3'b101, 3'b000, 3'b110};
    step(0, 1, 1, 0, 8'h44);
    foreach (pats[k]) begin
      step(pats[k][2], pats[k][1], pats[k][0], 0, 8'h99);
      chk(cmd_valid == 0, "R8", "idle pattern no cmd", cmd_valid, 0);
    end
    step(1, 0, 0, 0, 8'h66);
    chk(cmd_valid && cmd_addr == 8'h44, "R8", "latch kept over idle", cmd_addr, 8'h44);
    step(1, 1, 1, 0, 8'h00);
  endtask

  task automatic t_backpressure();
    cmd_ready = 1'b0;
    step(0, 1, 1, 1, 8'h50);
    step(1, 0, 0, 0, 8'h11);
    chk(cmd_valid == 1 && cmd_addr == 8'h50, "R9", "cmd loaded", cmd_addr, 8'h50);
    step(0, 1, 1, 1, 8'h51);
    chk(cmd_valid && cmd_addr == 8'h50 && cmd_wdata == 8'h11, "R9", "cmd held", cmd_wdata, 8'h11);
    step(1, 0, 0, 0, 8'h22);
    chk(err_drop == 1, "R9", "full slot drop err", err_drop, 1);
    chk(cmd_addr == 8'h50 && cmd_wdata == 8'h11, "R9", "cmd unchanged by drop", cmd_wdata, 8'h11);
    cmd_ready = 1'b1;
    step(1, 1, 1, 0, 8'h00);
    chk(cmd_valid == 0, "R9", "drained after ready", cmd_valid, 0);
    chk(mem[8'h50] == 8'h11, "R9", "accepted write stored", mem[8'h50], 8'h11);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_write();
    t_hold();
    t_read();
    t_busy_write();
    t_busy_read();
    t_idle();
    t_backpressure();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule